// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in physical memory. A caller presents a virtual address together with two qualifiers: whether the access is a write, and whether it comes from a user-mode requester. The walker then reads the top-level table entry, which is selected by the table-base frame input and the upper address bits. Next it reads the second-level entry, which is selected by the frame that the first entry supplies and the middle address bits. Finally it returns either the translated address or a fault code.

Both table levels use the same 32-bit entry layout. A successful translation marks the final entry as referenced, and marks it as modified when the access is a write. This status update is done as a read-modify-write over the same memory port. The write is issued only when a status bit really changes, and the answer is returned only after that write has been acknowledged. Only one walk is in flight at a time. While a walk is in progress the request side reports that it is not ready.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk targets address {`ptbr_frame`, va[31:22], 2'b00}. `ptbr_frame` is sampled when the request is accepted.
- R3: When the first-level entry is valid (bit 0), the second read targets {entry[31:12], va[21:12], 2'b00}.
- R4: A successful walk answers with fault code 0 and physical address {second-level entry[31:12], va[11:0]}.
- R5: A first-level entry whose bit 0 is clear ends the walk with fault code 1. Exactly one read is made and no write.
- R6: A second-level entry whose bit 0 is clear ends the walk with fault code 1 and no write.
- R7: On a valid second-level entry, the access is refused with fault code 2 and no write in any of these cases: a read without bit 1 (readable), a write without bit 2 (writable), or a user request without bit 3 (user-accessible).
- R8: A permitted access sets bit 4 (used) of the second-level entry. A permitted write also sets bit 5 (dirty). All other bits are written back unchanged, to the address of the second-level read.
- R9: The status write is issued only if it changes the entry. When it is issued, the response comes strictly after the write is acknowledged.
- R10: From acceptance until the response cycle, `req_ready` is 0. Each accepted request yields exactly one single-cycle `resp_valid` pulse. A memory request is held stable until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_frame | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = request from user mode |
| req_ready | output | 1 | Walker idle; a request is accepted when both req_valid and req_ready are 1 |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| resp_pa | output | 32 | Physical address; 0 on a fault |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = entry writeback, 0 = entry read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value for a writeback |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
A corrupted index extraction or a stale held frame shows up at the memory port. It appears as a wrong read address in the first or second read of the very walk that goes wrong, a few cycles after acceptance. A wrong permission or status decision appears at the end of the same walk in one of three forms: a fault code that does not match the entry's flags, a writeback that is missing or unnecessary, or a final entry in memory whose used or dirty bit differs from the expected one. Every flag combination is swept against every request kind, both with a memory that is always ready and with one that stalls every other cycle. A sequencing fault therefore shows up within one walk of roughly ten cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int PTE_W   = 32;
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int PAD_W   = OFF_W - IDX_W;

  // entry flag positions
  localparam int F_VALID = 0;
  localparam int F_READ  = 1;
  localparam int F_WRITE = 2;
  localparam int F_USER  = 3;
  localparam int F_USED  = 4;
  localparam int F_DIRTY = 5;
  localparam int FLAG_W  = F_DIRTY + 1;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_WB_REQ, S_WB_WAIT, S_RESP
  } walk_state_e;

  function automatic logic [IDX_W-1:0] top_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] leaf_index(input logic [VA_W-1:0] va);
    return va[OFF_W+IDX_W-1 -: IDX_W];
  endfunction

  function automatic logic [VA_W-1:0] slot_addr(input logic [FRAME_W-1:0] frame,
                                                input logic [IDX_W-1:0] idx);
    return {frame, idx, {PAD_W{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] join_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/pte_judge.sv
module pte_judge
  import ptw_pkg::*;
(
  input  logic [F_USER:0] flags,
  input  logic            is_write,
  input  logic            is_user,
  output logic            present,
  output logic            allowed
);
  logic kind_ok;
  logic mode_ok;

  always_comb begin
    present = flags[F_VALID];
    kind_ok = is_write ? flags[F_WRITE] : flags[F_READ];
    mode_ok = !is_user || flags[F_USER];
    allowed = kind_ok && mode_ok;
  end
endmodule

// File: rtl/pte_mark.sv
module pte_mark
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_in,
  input  logic             is_write,
  output logic [PTE_W-1:0] pte_out,
  output logic             changed
);
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask           = '0;
    set_mask[F_USED]   = 1'b1;
    set_mask[F_DIRTY]  = is_write;
    pte_out            = pte_in | set_mask;
    changed            = (pte_out != pte_in);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] ptbr_frame,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  input  logic               req_user,
  output logic               req_ready,
  output logic               resp_valid,
  output logic [1:0]         resp_fault,
  output logic [VA_W-1:0]    resp_pa,
  output logic               mem_req_valid,
  output logic               mem_req_write,
  output logic [VA_W-1:0]    mem_req_addr,
  output logic [PTE_W-1:0]   mem_req_wdata,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_rdata
);
  walk_state_e        state;
  logic [VA_W-1:0]    va_q;
  logic               wr_q, usr_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] table_q;
  logic [PTE_W-1:0]   wb_q;
  logic [VA_W-1:0]    pa_q;
  fault_e             fault_q;

  logic               rsp_present, rsp_allowed, rsp_changes;
  logic [PTE_W-1:0]   rsp_marked;

  // events brought out for the checker
  logic               l1_miss_ev, l2_miss_ev, perm_deny_ev, wb_needed_ev, leaf_ok_ev;

  pte_judge u_judge (
    .flags    (mem_rsp_rdata[F_USER:0]),
    .is_write (wr_q),
    .is_user  (usr_q),
    .present  (rsp_present),
    .allowed  (rsp_allowed)
  );

  pte_mark u_mark (
    .pte_in   (mem_rsp_rdata),
    .is_write (wr_q),
    .pte_out  (rsp_marked),
    .changed  (rsp_changes)
  );

  always_comb begin
    l1_miss_ev   = (state == S_L1_WAIT) && mem_rsp_valid && !rsp_present;
    l2_miss_ev   = (state == S_L2_WAIT) && mem_rsp_valid && !rsp_present;
    perm_deny_ev = (state == S_L2_WAIT) && mem_rsp_valid && rsp_present && !rsp_allowed;
    leaf_ok_ev   = (state == S_L2_WAIT) && mem_rsp_valid && rsp_present && rsp_allowed;
    wb_needed_ev = leaf_ok_ev && rsp_changes;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      base_q  <= '0;
      table_q <= '0;
      wb_q    <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          usr_q  <= req_user;
          base_q <= ptbr_frame;
          state  <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) state <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (l1_miss_ev) begin
            fault_q <= FLT_PAGE;
            pa_q    <= '0;
            state   <= S_RESP;
          end else begin
            table_q <= mem_rsp_rdata[PTE_W-1 -: FRAME_W];
            state   <= S_L2_REQ;
          end
        end
        S_L2_REQ: if (mem_req_ready) state <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          if (l2_miss_ev || perm_deny_ev) begin
            fault_q <= l2_miss_ev ? FLT_PAGE : FLT_PROT;
            pa_q    <= '0;
            state   <= S_RESP;
          end else begin
            fault_q <= FLT_NONE;
            pa_q    <= join_pa(mem_rsp_rdata[PTE_W-1 -: FRAME_W], va_q[OFF_W-1:0]);
            wb_q    <= rsp_marked;
            state   <= wb_needed_ev ? S_WB_REQ : S_RESP;
          end
        end
        S_WB_REQ:  if (mem_req_ready) state <= S_WB_WAIT;
        S_WB_WAIT: if (mem_rsp_valid) state <= S_RESP;
        S_RESP:    state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == S_IDLE);
    resp_valid    = (state == S_RESP);
    resp_fault    = fault_q;
    resp_pa       = pa_q;
    mem_req_valid = (state == S_L1_REQ) || (state == S_L2_REQ) || (state == S_WB_REQ);
    mem_req_write = (state == S_WB_REQ);
    mem_req_wdata = wb_q;
    if (state == S_L1_REQ) mem_req_addr = slot_addr(base_q, top_index(va_q));
    else                   mem_req_addr = slot_addr(table_q, leaf_index(va_q));
  end
endmodule

// File: rtl/pt_walker_props.sv
module pt_walker_props
  import ptw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [1:0]        resp_fault,
  input logic [OFF_W-1:0]  resp_off,
  input logic [OFF_W-1:0]  walk_off,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [VA_W-1:0]   mem_req_addr,
  input logic [FLAG_W-1:0] wb_flags,
  input logic              l1_miss_ev,
  input logic              l2_miss_ev,
  input logic              perm_deny_ev
);
  assert_busy_during_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_top_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    l1_miss_ev |=> (resp_valid && resp_fault == 2'd1));

  assert_leaf_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l2_miss_ev |=> (resp_valid && resp_fault == 2'd1));

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_deny_ev |=> (resp_valid && resp_fault == 2'd2));

  assert_wb_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (wb_flags[F_USED] && wb_flags[F_VALID]));

  assert_wb_before_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> !resp_valid);

  assert_offset_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == 2'd0) |-> (resp_off == walk_off));

  assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_fault != 2'd3));
endmodule

bind pt_walker pt_walker_props u_props (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .resp_valid    (resp_valid),
  .resp_fault    (resp_fault),
  .resp_off      (resp_pa[ptw_pkg::OFF_W-1:0]),
  .walk_off      (va_q[ptw_pkg::OFF_W-1:0]),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .wb_flags      (mem_req_wdata[ptw_pkg::FLAG_W-1:0]),
  .l1_miss_ev    (l1_miss_ev),
  .l2_miss_ev    (l2_miss_ev),
  .perm_deny_ev  (perm_deny_ev)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] ptbr_frame = 20'h00001;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        req_ready, resp_valid;
  logic [1:0]  resp_fault;
  logic [31:0] resp_pa;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;
  bit stall_en = 1'b0;
  logic [31:0] rd_log [4];
  logic [31:0] mem [int unsigned];

  always #2.5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .ptbr_frame(ptbr_frame),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: one-cycle response, optional stall on every other cycle
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rsp_rdata <= peek(mem_req_addr);
        rd_log[rd_cnt % 4] = mem_req_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
    mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one translation; expected values from the requirement text
  task automatic walk(input logic [31:0] va, input bit wr, input bit usr);
    logic [31:0] a1, a2, e1, e2, e2_new, exp_pa;
    logic [1:0]  exp_flt;
    int exp_rd, exp_wr, rd0, wr0, wait_n;
    a1 = (32'(ptbr_frame) << 12) | (32'(va >> 22) << 2);
    e1 = peek(a1);
    a2 = (e1 & 32'hFFFF_F000) | (((va >> 12) & 32'h3FF) << 2);
    e2 = peek(a2);
    e2_new = e2; exp_pa = 0; exp_wr = 0;
    if (!e1[0]) begin exp_flt = 1; exp_rd = 1; end
    else begin
      exp_rd = 2;
      if (!e2[0]) exp_flt = 1;
      else if ((wr ? !e2[2] : !e2[1]) || (usr && !e2[3])) exp_flt = 2;
      else begin
        exp_flt = 0;
        exp_pa = (e2 & 32'hFFFF_F000) + (va & 32'hFFF);
        e2_new = e2 | 32'h10 | (wr ? 32'h20 : 32'h0);
        exp_wr = (e2_new != e2) ? 1 : 0;
      end
    end
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10 busy after accept", {31'b0, req_ready}, 32'h0);
    wait_n = 0;
    while (!resp_valid && wait_n < 60) begin @(negedge clk); wait_n++; end
    check(resp_valid, "R10 response arrives", {31'b0, resp_valid}, 32'h1);
    check(resp_fault == exp_flt, exp_flt == 0 ? "R4 fault code" :
          (exp_flt == 2 ? "R7 protection" : (exp_rd == 1 ? "R5 top miss" : "R6 leaf miss")),
          {30'b0, resp_fault}, {30'b0, exp_flt});
    check(resp_pa == exp_pa, "R4 physical address", resp_pa, exp_pa);
    check(rd_cnt - rd0 == exp_rd, "R5 read count", 32'(rd_cnt - rd0), 32'(exp_rd));
    check(rd_log[rd0 % 4] == a1, "R2 top read addr", rd_log[rd0 % 4], a1);
    if (exp_rd == 2)
      check(rd_log[(rd0 + 1) % 4] == a2, "R3 leaf read addr", rd_log[(rd0 + 1) % 4], a2);
    check(wr_cnt - wr0 == exp_wr, "R9 writeback count", 32'(wr_cnt - wr0), 32'(exp_wr));
    if (exp_rd == 2)
      check(peek(a2) == e2_new, "R8 leaf entry status", peek(a2), e2_new);
    @(negedge clk);
    check(req_ready && !resp_valid, "R10 idle after pulse", {30'b0, req_ready, resp_valid}, 32'h2);
  endtask

  initial begin
    logic [31:0] leaf;
    repeat (3) @(negedge clk);
    check(req_ready && !resp_valid && !mem_req_valid, "R1 reset state",
          {29'b0, req_ready, resp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_req_valid, "R1 idle after reset",
          {29'b0, req_ready, resp_valid, mem_req_valid}, 32'h4);
    // top table at frame 1: indices 0..5 valid, 6 and 7 invalid
    for (int i = 0; i < 8; i++)
      mem[32'h1000 + 32'(i) * 4] = (i < 6) ? ((32'h10 + 32'(i)) << 12) | 32'h1 : 32'h0002_001E;
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int k = 0; k < 64; k++) begin
        for (int kind = 0; kind < 4; kind++) begin
          logic [31:0] va;
          int ti;
          ti = k % 6;
          va = (32'(ti) << 22) | (32'(k) << 12) | ((32'(k) * 32'h3B + 32'(kind)) & 32'hFFF);
          leaf = ((32'hABC00 + 32'(k)) << 12) | 32'(k);
          mem[((32'h10 + 32'(ti)) << 12) + 32'(k) * 4] = leaf;
          walk(va, kind[0], kind[1]);
        end
      end
      for (int t = 6; t < 8; t++)
        for (int kind = 0; kind < 4; kind++)
          walk((32'(t) << 22) | 32'h0003_4567, kind[0], kind[1]);
    end
    // table base moved: same index now resolves through a different top table
    ptbr_frame = 20'h00002;
    mem[32'h2000] = (32'h15 << 12) | 32'h1;
    mem[32'h15000] = (32'h77777 << 12) | 32'h07;
    walk(32'h0000_0ABC, 1'b1, 1'b0);
    walk(32'h0000_0ABC, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule